// File: doc/BRIEF.md
# Shadow Stack Return Checker

This block guards function returns inside a processor hart. It owns the shadow stack pointer register and carries out three shadow-stack operations against a simple memory port. A push saves the link register on the protected stack. A pop-and-check compares the saved value with the link register. An atomic swap exchanges a word at the pointer. Before any memory traffic, the block checks the permission bits of the addressed page. It also screens ordinary stores so that they cannot write a shadow-stack page.

The decoder presents one operation at a time, together with the current privilege mode, three per-mode enable bits, both candidate link registers and the permission bits of the page the access will touch. The block answers with a single-cycle completion strobe. On that same cycle it may raise an exception, which carries a cause code and a trap value.

A return whose saved address disagrees with the link register raises a software-check exception. A shadow-stack access to any page that lacks the shadow-stack encoding raises a store/AMO access fault. A read-only page counts as such a page, and this case is the hook software uses for copy-on-write.

The controller is a four-state machine:
- `S_IDLE` latches an operation and moves to `S_EVAL`.
- `S_EVAL` applies the mode gate and the permission check. It moves to `S_MEM` when a memory access is needed and to `S_RESP` otherwise.
- `S_MEM` holds the request until acknowledge and then moves to `S_RESP`.
- `S_RESP` raises the completion strobe for one cycle and returns to `S_IDLE`.

Top module: `ss_guard`

## Requirements
- R1: The feature is enabled per mode from a separate enable bit (bit 3 of the matching environment-configuration register, brought in as one wire):
  - supervisor with virt=0 uses `cfg_m_ss_en`;
  - supervisor with virt=1 uses `cfg_h_ss_en`;
  - user mode (either virt) uses `cfg_s_ss_en`;
  - machine mode is never enabled.
  - Privilege encoding: U=2'b00, S=2'b01, M=2'b11.
- R2: With the feature disabled for the current mode, push, pop-and-check and swap complete with no memory request, no SSP change and no exception.
- R3: Push (op_kind=1) first lowers SSP by XLEN/8. It then writes the selected link register to the new SSP, so that after completion SSP equals the written address.
- R4: Pop-and-check (op_kind=2) reads the word at SSP. When that word equals the selected link register, SSP rises by XLEN/8.
- R5: On a pop-and-check mismatch the block raises an exception with cause 18 and trap value 3, and leaves SSP unchanged. `lr_sel`=0 selects x1 and `lr_sel`=1 selects x5.
- R6: Page permissions are given as `page_perm` = {X,W,R}, and only the encoding 3'b010 is a shadow-stack page. A shadow-stack operation against any other page raises cause 7 with the access address as trap value. In that case no memory request is made and SSP is unchanged.
- R7: A plain store check (op_kind=4) raises cause 7 with `st_addr` as trap value unless the page has R=1 and W=1. This applies whether or not the feature is enabled, and a shadow-stack page therefore always faults.
- R8: Swap (op_kind=3) issues one atomic request (`mem_amo`=1, `mem_we`=1) at SSP. It writes `swap_data`, returns the old word on `swap_result`, and leaves SSP unchanged.
- R9: Reset clears SSP to 0. A write through `csr_we` loads SSP from `csr_wdata` at the next clock edge.
- R10: `done` is a one-cycle pulse per operation, and an exception is signalled only with `done`. `mem_req` stays high with a stable address until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, taken when idle |
| op_kind | input | 3 | 0 none, 1 push, 2 pop-and-check, 3 swap, 4 plain store check |
| priv | input | 2 | Current privilege mode |
| virt | input | 1 | Virtualised mode flag |
| cfg_m_ss_en | input | 1 | Enable for S/HS (machine-level config bit 3) |
| cfg_h_ss_en | input | 1 | Enable for VS (hypervisor config bit 3) |
| cfg_s_ss_en | input | 1 | Enable for U/VU (supervisor config bit 3) |
| lr_sel | input | 1 | Link register select: 0 x1, 1 x5 |
| lr_x1 | input | XLEN | Value of x1 |
| lr_x5 | input | XLEN | Value of x5 |
| swap_data | input | XLEN | Word written by swap |
| st_addr | input | XLEN | Address of a plain store being checked |
| page_perm | input | 3 | {X,W,R} of the addressed page |
| csr_we | input | 1 | Software write of SSP |
| csr_wdata | input | XLEN | SSP write data |
| ssp | output | XLEN | Current shadow stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request writes |
| mem_amo | output | 1 | Request is an atomic swap |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Request write data |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | XLEN | Read data |
| done | output | 1 | Operation complete |
| exc_valid | output | 1 | Exception raised with done |
| exc_cause | output | 6 | Exception cause |
| exc_tval | output | XLEN | Exception trap value |
| swap_result | output | XLEN | Old word returned by swap |

## Verification
A wrong internal state shows at the ports within one operation. A bad SSP update appears on `ssp` at the `done` cycle and on `mem_addr` of the next access. A mode-gate or permission error appears either as a memory request where none belongs or as a missing exception at `done`. A compare error flips the exception outcome of a return, which is why matched and mismatched returns are run through both x1 and x5.

// File: rtl/ss_guard_pkg.sv
`timescale 1ns/1ps
package ss_guard_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_PUSH     = 3'd1,
        OP_POPCHK   = 3'd2,
        OP_SWAP     = 3'd3,
        OP_PLAIN_ST = 3'd4
    } ss_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EVAL = 2'd1,
        S_MEM  = 2'd2,
        S_RESP = 2'd3
    } ss_state_e;

    localparam int CAUSE_W            = 6;
    localparam int CAUSE_SW_CHECK     = 18;
    localparam int CAUSE_STORE_FAULT  = 7;
    localparam int TVAL_RET_MISMATCH  = 3;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
endpackage

// File: rtl/ss_mode_gate.sv
`timescale 1ns/1ps
module ss_mode_gate
    import ss_guard_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       cfg_m_ss_en,
    input  logic       cfg_h_ss_en,
    input  logic       cfg_s_ss_en,
    output logic       enabled
);
    always_comb begin
        unique case (priv)
            PRIV_U:  enabled = cfg_s_ss_en;
            PRIV_S:  enabled = virt ? cfg_h_ss_en : cfg_m_ss_en;
            default: enabled = 1'b0;
        endcase
    end
endmodule

// File: rtl/ss_perm_check.sv
`timescale 1ns/1ps
module ss_perm_check (
    input  logic [2:0] perm,      // {X,W,R}
    output logic       ss_ok,     // page carries the shadow-stack encoding
    output logic       st_ok      // ordinary store allowed
);
    always_comb begin
        ss_ok = (perm == 3'b010);
        st_ok = perm[1] && perm[0];
    end
endmodule

// File: rtl/ss_guard.sv
`timescale 1ns/1ps
module ss_guard
    import ss_guard_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [2:0]          op_kind,
    input  logic [1:0]          priv,
    input  logic                virt,
    input  logic                cfg_m_ss_en,
    input  logic                cfg_h_ss_en,
    input  logic                cfg_s_ss_en,
    input  logic                lr_sel,
    input  logic [XLEN-1:0]     lr_x1,
    input  logic [XLEN-1:0]     lr_x5,
    input  logic [XLEN-1:0]     swap_data,
    input  logic [XLEN-1:0]     st_addr,
    input  logic [2:0]          page_perm,
    input  logic                csr_we,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     ssp,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_amo,
    output logic [XLEN-1:0]     mem_addr,
    output logic [XLEN-1:0]     mem_wdata,
    input  logic                mem_ack,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                done,
    output logic                exc_valid,
    output logic [CAUSE_W-1:0]  exc_cause,
    output logic [XLEN-1:0]     exc_tval,
    output logic [XLEN-1:0]     swap_result
);
    localparam int            STEP_BYTES = XLEN / 8;
    localparam logic [XLEN-1:0] STEP     = XLEN'(STEP_BYTES);

    ss_state_e state, state_nx;
    ss_op_e    op_q;

    logic              mode_en, ss_ok, st_ok;
    logic              en_q, ss_ok_q, st_ok_q;
    logic [XLEN-1:0]   ssp_q, lr_q, swap_q, st_addr_q;
    logic [XLEN-1:0]   addr_q, wdata_q, tval_q, res_q, acc_addr;
    logic              exc_q;
    logic [CAUSE_W-1:0] cause_q;
    logic              start;

    ss_mode_gate u_gate (
        .priv        (priv),
        .virt        (virt),
        .cfg_m_ss_en (cfg_m_ss_en),
        .cfg_h_ss_en (cfg_h_ss_en),
        .cfg_s_ss_en (cfg_s_ss_en),
        .enabled     (mode_en)
    );

    ss_perm_check u_perm (
        .perm  (page_perm),
        .ss_ok (ss_ok),
        .st_ok (st_ok)
    );

    assign start    = op_valid && (op_kind != OP_NOP);
    assign acc_addr = (op_q == OP_PUSH) ? (ssp_q - STEP) : ssp_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_EVAL;
            S_EVAL: state_nx = (op_q != OP_PLAIN_ST && en_q && ss_ok_q) ? S_MEM : S_RESP;
            S_MEM:  if (mem_ack) state_nx = S_RESP;
            S_RESP: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_NOP;
            en_q      <= 1'b0;
            ss_ok_q   <= 1'b0;
            st_ok_q   <= 1'b0;
            ssp_q     <= '0;
            lr_q      <= '0;
            swap_q    <= '0;
            st_addr_q <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            tval_q    <= '0;
            res_q     <= '0;
            exc_q     <= 1'b0;
            cause_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    op_q      <= ss_op_e'(op_kind);
                    lr_q      <= lr_sel ? lr_x5 : lr_x1;
                    swap_q    <= swap_data;
                    st_addr_q <= st_addr;
                    en_q      <= mode_en;
                    ss_ok_q   <= ss_ok;
                    st_ok_q   <= st_ok;
                    exc_q     <= 1'b0;
                    cause_q   <= '0;
                    tval_q    <= '0;
                end
                S_EVAL: begin
                    if (op_q == OP_PLAIN_ST) begin
                        if (!st_ok_q) begin
                            exc_q   <= 1'b1;
                            cause_q <= CAUSE_W'(CAUSE_STORE_FAULT);
                            tval_q  <= st_addr_q;
                        end
                    end else if (en_q) begin
                        if (!ss_ok_q) begin
                            exc_q   <= 1'b1;
                            cause_q <= CAUSE_W'(CAUSE_STORE_FAULT);
                            tval_q  <= acc_addr;
                        end else begin
                            addr_q  <= acc_addr;
                            wdata_q <= (op_q == OP_SWAP) ? swap_q : lr_q;
                        end
                    end
                end
                S_MEM: if (mem_ack) begin
                    unique case (op_q)
                        OP_PUSH:   ssp_q <= addr_q;
                        OP_POPCHK: begin
                            if (mem_rdata == lr_q) begin
                                ssp_q <= addr_q + STEP;
                            end else begin
                                exc_q   <= 1'b1;
                                cause_q <= CAUSE_W'(CAUSE_SW_CHECK);
                                tval_q  <= XLEN'(TVAL_RET_MISMATCH);
                            end
                        end
                        OP_SWAP:   res_q <= mem_rdata;
                        default:   ;
                    endcase
                end
                default: ;
            endcase
            if (csr_we) ssp_q <= csr_wdata;
        end
    end

    // outputs
    always_comb begin
        mem_req     = (state == S_MEM);
        mem_we      = (op_q != OP_POPCHK);
        mem_amo     = (op_q == OP_SWAP);
        mem_addr    = addr_q;
        mem_wdata   = wdata_q;
        done        = (state == S_RESP);
        exc_valid   = (state == S_RESP) && exc_q;
        exc_cause   = cause_q;
        exc_tval    = tval_q;
        swap_result = res_q;
        ssp         = ssp_q;
    end
endmodule

// File: rtl/ss_guard_chk.sv
`timescale 1ns/1ps
module ss_guard_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            csr_we,
    input logic [XLEN-1:0] ssp,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_amo,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_ack,
    input logic            done,
    input logic            exc_valid,
    input logic [5:0]      exc_cause,
    input logic [XLEN-1:0] exc_tval
);
    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> done && !mem_req); // R10
    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_we && !mem_amo && !csr_we |=> ssp == $past(mem_addr)); // R3
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we && !csr_we |=>
        (ssp == $past(mem_addr) + STEP) || (ssp == $past(mem_addr))); // R4
    AST_MISMATCH_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && exc_cause == 6'd18 |-> exc_tval == XLEN'(3)); // R5
    AST_FAULT_KEEPS_SSP: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid && !$past(csr_we) |-> $stable(ssp)); // R6
    AST_AMO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_amo |-> mem_we && mem_addr == ssp); // R8
endmodule

bind ss_guard ss_guard_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .ssp       (ssp),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_amo   (mem_amo),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .done      (done),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .exc_tval  (exc_tval)
);

// File: tb/ss_guard_tb.sv
`timescale 1ns/1ps
module ss_guard_tb;
    localparam int XLEN = 64;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  priv;
        logic        virt;
        logic [2:0]  ens;     // {m,h,s}
        logic        sel;
        logic [2:0]  perm;    // {X,W,R}
        logic [63:0] top;
        logic        exc;
        logic [5:0]  cause;
        logic [63:0] tval;
        logic [63:0] ssp;
        logic [3:0]  acc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'b01, 1'b0, 3'b100, 1'b0, 3'b010, 64'h0,  1'b0, 6'd0,  64'h0,    64'hFF8,  4'd1, 4'd3},  // R3 push S
        '{3'd2, 2'b01, 1'b0, 3'b100, 1'b0, 3'b010, 64'hA1, 1'b0, 6'd0,  64'h0,    64'h1008, 4'd1, 4'd4},  // R4 pop x1 match
        '{3'd2, 2'b00, 1'b0, 3'b001, 1'b1, 3'b010, 64'hA5, 1'b0, 6'd0,  64'h0,    64'h1008, 4'd1, 4'd5},  // R5 pop x5 match
        '{3'd2, 2'b01, 1'b0, 3'b100, 1'b0, 3'b010, 64'hA5, 1'b1, 6'd18, 64'h3,    64'h1000, 4'd1, 4'd5},  // R5 x1 mismatch
        '{3'd2, 2'b01, 1'b0, 3'b100, 1'b1, 3'b010, 64'hA1, 1'b1, 6'd18, 64'h3,    64'h1000, 4'd1, 4'd5},  // R5 x5 mismatch
        '{3'd1, 2'b00, 1'b0, 3'b110, 1'b0, 3'b010, 64'h0,  1'b0, 6'd0,  64'h0,    64'h1000, 4'd0, 4'd1},  // R1 U off
        '{3'd1, 2'b01, 1'b1, 3'b010, 1'b0, 3'b010, 64'h0,  1'b0, 6'd0,  64'h0,    64'hFF8,  4'd1, 4'd1},  // R1 VS on
        '{3'd1, 2'b01, 1'b1, 3'b101, 1'b0, 3'b010, 64'h0,  1'b0, 6'd0,  64'h0,    64'h1000, 4'd0, 4'd1},  // R1 VS off
        '{3'd1, 2'b11, 1'b0, 3'b111, 1'b0, 3'b010, 64'h0,  1'b0, 6'd0,  64'h0,    64'h1000, 4'd0, 4'd2},  // R2 M never
        '{3'd2, 2'b00, 1'b0, 3'b000, 1'b0, 3'b010, 64'hA5, 1'b0, 6'd0,  64'h0,    64'h1000, 4'd0, 4'd2},  // R2 off pop
        '{3'd1, 2'b01, 1'b0, 3'b100, 1'b0, 3'b001, 64'h0,  1'b1, 6'd7,  64'hFF8,  64'h1000, 4'd0, 4'd6},  // R6 push RO
        '{3'd2, 2'b01, 1'b0, 3'b100, 1'b0, 3'b001, 64'hA1, 1'b1, 6'd7,  64'h1000, 64'h1000, 4'd0, 4'd6},  // R6 pop RO
        '{3'd2, 2'b01, 1'b0, 3'b100, 1'b0, 3'b011, 64'hA1, 1'b1, 6'd7,  64'h1000, 64'h1000, 4'd0, 4'd6},  // R6 pop RW
        '{3'd4, 2'b01, 1'b0, 3'b000, 1'b0, 3'b010, 64'h0,  1'b1, 6'd7,  64'h2000, 64'h1000, 4'd0, 4'd7},  // R7 st SS
        '{3'd4, 2'b01, 1'b0, 3'b100, 1'b0, 3'b011, 64'h0,  1'b0, 6'd0,  64'h0,    64'h1000, 4'd0, 4'd7},  // R7 st RW
        '{3'd4, 2'b00, 1'b0, 3'b001, 1'b0, 3'b001, 64'h0,  1'b1, 6'd7,  64'h2000, 64'h1000, 4'd0, 4'd7},  // R7 st RO
        '{3'd3, 2'b01, 1'b0, 3'b100, 1'b0, 3'b010, 64'h77, 1'b0, 6'd0,  64'h0,    64'h1000, 4'd1, 4'd8}   // R8 swap
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [2:0]      op_kind = 3'd0;
    logic [1:0]      priv = 2'b00;
    logic            virt = 1'b0;
    logic            cfg_m_ss_en = 1'b0, cfg_h_ss_en = 1'b0, cfg_s_ss_en = 1'b0;
    logic            lr_sel = 1'b0;
    logic [XLEN-1:0] lr_x1 = 64'hA1, lr_x5 = 64'hA5;
    logic [XLEN-1:0] swap_data = 64'h55, st_addr = 64'h2000;
    logic [2:0]      page_perm = 3'b010;
    logic            csr_we = 1'b0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] ssp, mem_addr, mem_wdata, mem_rdata, exc_tval, swap_result;
    logic            mem_req, mem_we, mem_amo, mem_ack, done, exc_valid;
    logic [5:0]      exc_cause;

    logic [63:0] mem [16];
    int          acc_cnt = 0;
    int          n_chk = 0, n_fail = 0, cycles = 0;

    logic        r_exc;
    logic [5:0]  r_cause;
    logic [63:0] r_tval, r_ssp, r_res;

    always #2.5 clk = ~clk;   // 200 MHz

    ss_guard #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .priv(priv), .virt(virt), .cfg_m_ss_en(cfg_m_ss_en),
        .cfg_h_ss_en(cfg_h_ss_en), .cfg_s_ss_en(cfg_s_ss_en),
        .lr_sel(lr_sel), .lr_x1(lr_x1), .lr_x5(lr_x5), .swap_data(swap_data),
        .st_addr(st_addr), .page_perm(page_perm), .csr_we(csr_we),
        .csr_wdata(csr_wdata), .ssp(ssp), .mem_req(mem_req), .mem_we(mem_we),
        .mem_amo(mem_amo), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval),
        .swap_result(swap_result)
    );

    // memory model: one-cycle registered acknowledge
    initial mem_ack = 1'b0;
    initial mem_rdata = '0;
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[6:3]];
            if (mem_we) mem[mem_addr[6:3]] <= mem_wdata;
            acc_cnt   <= acc_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    task automatic preset(input logic [63:0] sp, input logic [63:0] top);
        @(negedge clk);
        csr_we    = 1'b1;
        csr_wdata = sp;
        mem[sp[6:3]] = top;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] pv, input logic vt,
                         input logic [2:0] ens, input logic sel, input logic [2:0] perm);
        logic seen;
        @(negedge clk);
        op_kind = op; priv = pv; virt = vt;
        {cfg_m_ss_en, cfg_h_ss_en, cfg_s_ss_en} = ens;
        lr_sel = sel; page_perm = perm;
        acc_cnt = 0;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk("R10", "done seen", 64'(seen), 64'd1);
        r_exc = exc_valid; r_cause = exc_cause; r_tval = exc_tval;
        r_ssp = ssp; r_res = swap_result;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "reset ssp", ssp, 64'h0);
        chk("R10", "reset done", 64'(done), 64'd0);
        chk("R10", "reset mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        // R9 software write
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = 64'h1234;
        @(negedge clk);
        csr_we = 1'b0;
        chk("R9", "csr write", ssp, 64'h1234);

        // table walk
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[v].req);
            preset(64'h1000, VECS[v].top);
            issue(VECS[v].op, VECS[v].priv, VECS[v].virt, VECS[v].ens,
                  VECS[v].sel, VECS[v].perm);
            chk(tag, $sformatf("vec%0d exc", v), 64'(r_exc), 64'(VECS[v].exc));
            if (VECS[v].exc) begin
                chk(tag, $sformatf("vec%0d cause", v), 64'(r_cause), 64'(VECS[v].cause));
                chk(tag, $sformatf("vec%0d tval", v), r_tval, VECS[v].tval);
            end
            chk(tag, $sformatf("vec%0d ssp", v), r_ssp, VECS[v].ssp);
            chk(tag, $sformatf("vec%0d accesses", v), 64'(acc_cnt), 64'(VECS[v].acc));
            if (VECS[v].op == 3'd3)
                chk(tag, $sformatf("vec%0d swap old", v), r_res, 64'h77);
        end

        // R3: push from x5 stores the link value at the lowered pointer
        preset(64'h1000, 64'h0);
        issue(3'd1, 2'b00, 1'b0, 3'b001, 1'b1, 3'b010);
        chk("R3", "push data x5", mem[15], 64'hA5);
        chk("R3", "push ssp", r_ssp, 64'hFF8);
        // R10: strobe lasts one cycle
        @(negedge clk);
        chk("R10", "done one cycle", 64'(done), 64'd0);
        // R4: matching pop returns the pointer to its start
        issue(3'd2, 2'b00, 1'b0, 3'b001, 1'b1, 3'b010);
        chk("R4", "pop after push exc", 64'(r_exc), 64'd0);
        chk("R4", "pop after push ssp", r_ssp, 64'h1000);

        // R8: swap writes new word, returns old
        preset(64'h1000, 64'h77);
        issue(3'd3, 2'b01, 1'b0, 3'b100, 1'b0, 3'b010);
        chk("R8", "swap memory", mem[0], 64'h55);
        chk("R8", "swap result", r_res, 64'h77);

        // R2: disabled swap leaves memory alone
        preset(64'h1000, 64'h99);
        issue(3'd3, 2'b00, 1'b0, 3'b110, 1'b0, 3'b010);
        chk("R2", "disabled swap memory", mem[0], 64'h99);
        chk("R2", "disabled swap accesses", 64'(acc_cnt), 64'd0);

        finish_run();
    end
endmodule